// File: doc/BRIEF.md
# Domain-Tagged Permission Lookaside Cache

This block caches fine-grained memory permissions for a single shared address space split into protection domains. Each lookup presents a 32-bit virtual address, an access kind and the domain currently running. One cycle later the block reports whether a cached entry covered that address for that domain, the 2-bit permission held by the entry, and whether the requested access breaks that permission. No address translation takes place. The only result is permission data.

Each entry covers a naturally aligned, power-of-two sized range. The entry stores a mask, and the low address bits under that mask are ignored when the address is compared with the entry's base. This is the ternary-match style of a content-addressable memory. An external table walker loads entries after a miss through the refill port, and replacement is round-robin. The invalidate port removes every entry that belongs to one domain in a single cycle. This is used when that domain's permissions are revoked.

Top module: `plb_top`

## Requirements
- R1: After synchronous reset, `rsp_valid` is low, every entry is invalid, and every lookup misses until a refill is made.
- R2: A lookup presented with `lk_valid` high on a clock edge produces `rsp_valid` high on the next edge. `rsp_valid` is low after any edge where `lk_valid` was low, so back-to-back lookups are accepted every cycle.
- R3: An entry can hit only when its stored domain ID equals `lk_dom`.
- R4: An entry with size code S (`fill_size`, 0..31) matches when address bits 31..S equal the same bits of its base. Bits below S are ignored. S=0 covers one byte address, and S=8 covers a 256-byte aligned block.
- R5: On a hit, `rsp_perm` returns the entry's permission unchanged, encoded 0 = none, 1 = read-only, 2 = read-write, 3 = execute-read.
- R6: On a hit, the access code `lk_acc` (0 = read, 1 = write, 2 = fetch) is allowed as follows. A read is allowed for codes 1, 2 and 3. A write is allowed only for code 2. A fetch is allowed only for code 3. `rsp_fault` is high exactly when the access is not allowed.
- R7: On a miss, `rsp_hit`, `rsp_perm` and `rsp_fault` are all zero.
- R8: When several valid entries match, the entry with the lowest index supplies the result.
- R9: Refills write slots in round-robin order starting at slot 0 after reset, wrapping after the last of the 16 slots. A refill overwrites whatever the slot held.
- R10: An invalidate request removes, in one cycle, every valid entry whose domain equals `inv_dom`. Entries of other domains keep hitting.
- R11: When a refill and an invalidate of the same domain arrive in the same cycle, the newly written entry survives, and all older entries of that domain are removed.
- R12: Access code 3 is reserved, and it raises `rsp_fault` on every hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Virtual address to check |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| lk_dom | input | 8 | Domain issuing the access |
| rsp_valid | output | 1 | Result valid, one cycle after the lookup |
| rsp_hit | output | 1 | A cached entry covered the lookup |
| rsp_perm | output | 2 | Permission of the selected entry |
| rsp_fault | output | 1 | The access breaks the permission on a hit |
| fill_valid | input | 1 | Write one entry into the next round-robin slot |
| fill_dom | input | 8 | Domain owning the new entry |
| fill_base | input | 32 | Base address of the new entry's range |
| fill_size | input | 5 | Log2 of the range size in bytes |
| fill_perm | input | 2 | Permission of the new entry |
| inv_valid | input | 1 | Invalidate all entries of one domain |
| inv_dom | input | 8 | Domain to invalidate |

## Verification
A corrupted entry, domain tag or mask shows up at the ports on the first lookup that touches it. That lookup returns a hit where a miss is due, or the reverse, or the wrong permission one cycle after the request. A replacement pointer that drifts does not show up at once. It appears only when a later refill overwrites a slot that should have survived, so the bench fills past the wrap point and probes older entries. A faulty invalidate is caught by probing both the revoked domain and a bystander domain in the cycle right after the request. Overlapping ranges check the priority choice.

// File: rtl/plb_pkg.sv
package plb_pkg;

    parameter int PLB_ADDR_W = 32;
    parameter int PLB_DOM_W  = 8;
    parameter int PLB_SIZE_W = $clog2(PLB_ADDR_W);

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_XR   = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic                  valid;
        logic [PLB_DOM_W-1:0]  dom;
        logic [PLB_ADDR_W-1:0] mask;
        logic [PLB_ADDR_W-1:0] tag;
        perm_e                 perm;
    } plb_entry_t;

    // Care-bit mask: ones above the ignored low bits.
    function automatic logic [PLB_ADDR_W-1:0] range_mask(input logic [PLB_SIZE_W-1:0] sz);
        return {PLB_ADDR_W{1'b1}} << sz;
    endfunction

    function automatic logic access_ok(input perm_e p, input acc_e a);
        logic ok;
        unique case (a)
            ACC_READ:  ok = (p != PERM_NONE);
            ACC_WRITE: ok = (p == PERM_RW);
            ACC_FETCH: ok = (p == PERM_XR);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/plb_entry_store.sv
module plb_entry_store
    import plb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [PLB_ADDR_W-1:0]             lk_addr,
    input  logic [PLB_DOM_W-1:0]              lk_dom,
    input  logic                              fill_valid,
    input  logic [PLB_DOM_W-1:0]              fill_dom,
    input  logic [PLB_ADDR_W-1:0]             fill_base,
    input  logic [PLB_SIZE_W-1:0]             fill_size,
    input  perm_e                             fill_perm,
    input  logic                              inv_valid,
    input  logic [PLB_DOM_W-1:0]              inv_dom,
    output logic [ENTRIES-1:0]                hit_vec,
    output logic [ENTRIES-1:0][1:0]           perm_vec
);

    plb_entry_t          ent [ENTRIES];
    logic [IDX_W-1:0]    ptr;
    logic [ENTRIES-1:0]  valid_vec;
    logic [ENTRIES-1:0]  same_dom;
    plb_entry_t          new_ent;

    always_comb begin
        new_ent.valid = 1'b1;
        new_ent.dom   = fill_dom;
        new_ent.mask  = range_mask(fill_size);
        new_ent.tag   = fill_base & range_mask(fill_size);
        new_ent.perm  = fill_perm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent[i].valid <= 1'b0;
                ent[i].dom   <= '0;
                ent[i].mask  <= '0;
                ent[i].tag   <= '0;
                ent[i].perm  <= PERM_NONE;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_valid && ptr == IDX_W'(i)) begin
                    ent[i] <= new_ent;
                end else if (inv_valid && ent[i].valid && ent[i].dom == inv_dom) begin
                    ent[i].valid <= 1'b0;
                end
            end
            if (fill_valid) begin
                ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign valid_vec[g] = ent[g].valid;
        assign same_dom[g]  = ent[g].valid && (ent[g].dom == inv_dom);
        assign hit_vec[g]   = ent[g].valid && (ent[g].dom == lk_dom) &&
                              ((lk_addr & ent[g].mask) == ent[g].tag);
        assign perm_vec[g]  = ent[g].perm;
    end

    // R9
    rr_slot_written_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> valid_vec[$past(ptr)]);

    // R10
    inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_valid && !fill_valid) |=> (($past(same_dom) & valid_vec) == '0));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        $past(rst) |-> (valid_vec == '0));

endmodule

// File: rtl/plb_prio_pick.sv
module plb_prio_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    logic [ENTRIES-1:0] gnt;

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
        gnt = any ? (ENTRIES'(1) << idx) : '0;
    end

    // R8
    always_comb begin
        lowest_wins_chk: assert ((((gnt - 1'b1) & req) == '0) && $onehot0(gnt));
    end

endmodule

// File: rtl/plb_perm_check.sv
module plb_perm_check
    import plb_pkg::*;
(
    input  logic  hit,
    input  perm_e perm,
    input  acc_e  acc,
    output logic  fault
);

    assign fault = hit && !access_ok(perm, acc);

    // R12
    always_comb begin
        rsvd_faults_chk: assert (!(hit && acc == ACC_RSVD) || fault);
    end

endmodule

// File: rtl/plb_top.sv
module plb_top
    import plb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lk_valid,
    input  logic [PLB_ADDR_W-1:0]  lk_addr,
    input  logic [1:0]             lk_acc,
    input  logic [PLB_DOM_W-1:0]   lk_dom,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic [1:0]             rsp_perm,
    output logic                   rsp_fault,
    input  logic                   fill_valid,
    input  logic [PLB_DOM_W-1:0]   fill_dom,
    input  logic [PLB_ADDR_W-1:0]  fill_base,
    input  logic [PLB_SIZE_W-1:0]  fill_size,
    input  logic [1:0]             fill_perm,
    input  logic                   inv_valid,
    input  logic [PLB_DOM_W-1:0]   inv_dom
);

    logic [ENTRIES-1:0]      hit_vec;
    logic [ENTRIES-1:0][1:0] perm_vec;
    logic [IDX_W-1:0]        sel_idx;
    logic                    sel_any;
    perm_e                   sel_perm;
    logic                    acc_fault;

    plb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .lk_addr    (lk_addr),
        .lk_dom     (lk_dom),
        .fill_valid (fill_valid),
        .fill_dom   (fill_dom),
        .fill_base  (fill_base),
        .fill_size  (fill_size),
        .fill_perm  (perm_e'(fill_perm)),
        .inv_valid  (inv_valid),
        .inv_dom    (inv_dom),
        .hit_vec    (hit_vec),
        .perm_vec   (perm_vec)
    );

    plb_prio_pick #(.ENTRIES(ENTRIES)) u_pick (
        .req (hit_vec),
        .idx (sel_idx),
        .any (sel_any)
    );

    assign sel_perm = sel_any ? perm_e'(perm_vec[sel_idx]) : PERM_NONE;

    plb_perm_check u_check (
        .hit   (sel_any),
        .perm  (sel_perm),
        .acc   (acc_e'(lk_acc)),
        .fault (acc_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_perm  <= 2'd0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && sel_any;
            rsp_perm  <= lk_valid ? sel_perm : PERM_NONE;
            rsp_fault <= lk_valid && acc_fault;
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R7
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_perm == 2'd0 && !rsp_fault));

    // R6
    fault_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_hit));

endmodule

// File: tb/test_plb_top.sv
module test_plb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_acc = '0;
    logic [7:0]  lk_dom = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [1:0]  rsp_perm;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_dom = '0;
    logic [31:0] fill_base = '0;
    logic [4:0]  fill_size = '0;
    logic [1:0]  fill_perm = '0;
    logic        inv_valid = 1'b0;
    logic [7:0]  inv_dom = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    plb_top i_plb_top (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_acc(lk_acc), .lk_dom(lk_dom),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault),
        .fill_valid(fill_valid), .fill_dom(fill_dom), .fill_base(fill_base),
        .fill_size(fill_size), .fill_perm(fill_perm),
        .inv_valid(inv_valid), .inv_dom(inv_dom)
    );

    // Reference model of the 16 slots, built from the requirements.
    bit          m_valid [16];
    logic [7:0]  m_dom   [16];
    logic [31:0] m_base  [16];
    logic [4:0]  m_size  [16];
    logic [1:0]  m_perm  [16];
    int          m_ptr = 0;

    typedef struct {
        logic       hit;
        logic [1:0] perm;
        logic       fault;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    function automatic bit allowed(input logic [1:0] p, input logic [1:0] a);
        if (a == 2'd0) return p != 2'd0;
        if (a == 2'd1) return p == 2'd2;
        if (a == 2'd2) return p == 2'd3;
        return 1'b0;
    endfunction

    function automatic exp_t model_lookup(input logic [31:0] a, input logic [1:0] acc,
                                          input logic [7:0] d, input string tag);
        exp_t e;
        e.hit = 1'b0; e.perm = 2'd0; e.fault = 1'b0; e.tag = tag;
        for (int i = 0; i < 16; i++) begin
            if (!e.hit && m_valid[i] && m_dom[i] == d &&
                ((a ^ m_base[i]) >> m_size[i]) == 32'd0) begin
                e.hit = 1'b1;
                e.perm = m_perm[i];
                e.fault = !allowed(m_perm[i], acc);
            end
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic lookup(input logic [31:0] a, input logic [1:0] acc,
                          input logic [7:0] d, input string tag);
        @(negedge clk);
        sb_q.push_back(model_lookup(a, acc, d, tag));
        lk_addr = a; lk_acc = acc; lk_dom = d; lk_valid = 1'b1;
        @(posedge clk);
        #1 lk_valid = 1'b0;
    endtask

    task automatic update(input bit do_fill, input logic [7:0] fd, input logic [31:0] fb,
                          input logic [4:0] fs, input logic [1:0] fp,
                          input bit do_inv, input logic [7:0] id);
        @(negedge clk);
        fill_valid = do_fill; fill_dom = fd; fill_base = fb; fill_size = fs; fill_perm = fp;
        inv_valid = do_inv; inv_dom = id;
        @(posedge clk);
        #1 fill_valid = 1'b0; inv_valid = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (do_fill && i == m_ptr) begin
                m_valid[i] = 1'b1; m_dom[i] = fd; m_base[i] = fb; m_size[i] = fs; m_perm[i] = fp;
            end else if (do_inv && m_valid[i] && m_dom[i] == id) begin
                m_valid[i] = 1'b0;
            end
        end
        if (do_fill) m_ptr = (m_ptr + 1) % 16;
    endtask

    task automatic fill(input logic [7:0] fd, input logic [31:0] fb,
                        input logic [4:0] fs, input logic [1:0] fp);
        update(1'b1, fd, fb, fs, fp, 1'b0, 8'd0);
    endtask

    // Monitor: pop and compare every response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_hit == e.hit, {e.tag, " hit"}, int'(rsp_hit), int'(e.hit));
                check(rsp_perm == e.perm, {e.tag, " perm"}, int'(rsp_perm), int'(e.perm));
                check(rsp_fault == e.fault, {e.tag, " fault"}, int'(rsp_fault), int'(e.fault));
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 1'b0; m_dom[i] = '0; m_base[i] = '0; m_size[i] = '0; m_perm[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        lookup(32'h0000_1000, 2'd0, 8'd1, "R1 empty lookup misses");
        lookup(32'h0000_0000, 2'd1, 8'd0, "R7 miss outputs zero");

        // slot 0: domain 1, 256 B at 0x1000, read-write
        fill(8'd1, 32'h0000_1000, 5'd8, 2'd2);
        lookup(32'h0000_1000, 2'd0, 8'd1, "R5 read on rw");
        lookup(32'h0000_10FC, 2'd1, 8'd1, "R4 top of range write");
        lookup(32'h0000_1100, 2'd0, 8'd1, "R4 just past range");
        lookup(32'h0000_1000, 2'd0, 8'd2, "R3 other domain");
        lookup(32'h0000_1010, 2'd2, 8'd1, "R6 fetch on rw");
        lookup(32'h0000_1010, 2'd3, 8'd1, "R12 reserved access");

        // slot 1: domain 1, 4 KB at 0x1000, execute-read (overlaps slot 0)
        fill(8'd1, 32'h0000_1234, 5'd12, 2'd3);
        lookup(32'h0000_1004, 2'd1, 8'd1, "R8 lower slot wins");
        lookup(32'h0000_1800, 2'd2, 8'd1, "R6 fetch on xr");
        lookup(32'h0000_1800, 2'd1, 8'd1, "R6 write on xr");
        lookup(32'h0000_1800, 2'd0, 8'd1, "R6 read on xr");

        // slot 2: domain 2, 4 B at 0x1000, read-only
        fill(8'd2, 32'h0000_1000, 5'd2, 2'd1);
        lookup(32'h0000_1003, 2'd0, 8'd2, "R4 small range read");
        lookup(32'h0000_1004, 2'd0, 8'd2, "R4 small range edge");
        lookup(32'h0000_1000, 2'd1, 8'd2, "R6 write on ro");

        // slot 3: domain 1, single byte 0x2000, no access
        fill(8'd1, 32'h0000_2000, 5'd0, 2'd0);
        lookup(32'h0000_2000, 2'd0, 8'd1, "R6 read on none");
        lookup(32'h0000_2001, 2'd0, 8'd1, "R4 exact address only");

        // revoke domain 1
        update(1'b0, 8'd0, 32'd0, 5'd0, 2'd0, 1'b1, 8'd1);
        lookup(32'h0000_1000, 2'd0, 8'd1, "R10 revoked domain misses");
        lookup(32'h0000_2000, 2'd0, 8'd1, "R10 revoked byte misses");
        lookup(32'h0000_1000, 2'd0, 8'd2, "R10 bystander domain hits");

        // round robin: slots 4..15 then wrap to 0, 1, 2
        for (int k = 0; k < 12; k++) fill(8'd3, 32'(k) << 16, 5'd4, 2'd2);
        fill(8'd3, 32'h000F_0000, 5'd4, 2'd1);
        lookup(32'h0000_1000, 2'd0, 8'd2, "R9 slot 2 kept after wrap");
        lookup(32'h0003_0008, 2'd1, 8'd3, "R9 mid slot hits");
        lookup(32'h000F_0000, 2'd0, 8'd3, "R9 wrapped into slot 0");
        fill(8'd3, 32'h0010_0000, 5'd4, 2'd2);
        fill(8'd3, 32'h0020_0000, 5'd4, 2'd2);
        lookup(32'h0000_1000, 2'd0, 8'd2, "R9 slot 2 overwritten");
        lookup(32'h0020_0004, 2'd1, 8'd3, "R9 newest entry hits");

        // same-cycle refill and invalidate of domain 3
        update(1'b1, 8'd3, 32'h0000_5000, 5'd8, 2'd2, 1'b1, 8'd3);
        lookup(32'h0000_5010, 2'd1, 8'd3, "R11 new entry survives");
        lookup(32'h0003_0008, 2'd0, 8'd3, "R11 old entry removed");
        lookup(32'h0020_0004, 2'd0, 8'd3, "R11 newest old removed");

        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R2 rsp_valid low when idle", int'(rsp_valid), 0);
        check(sb_q.size() == 0, "R2 all responses seen", sb_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule